// File: doc/BRIEF.md
# SD Host Timeout Monitor

This block sits beside the command and data state machines of an SD host controller and watches how long each phase of a transaction waits. The state machines send one-cycle phase strobes: command issued, response received, write block sent, CRC status token received, read block received, read-wait exit and R1b response received. The monitor also sees the sampled DAT0 level, a qualifier that marks a command as an automatic stop command, and a 4-bit timeout selection field. When a wait runs too long it sets a sticky timeout bit.

A response must arrive within a fixed 640 card-clock ticks. Five data-phase waits use a programmable period: CRC status token after a write block, card busy after the token, read data, busy after the response to an automatic stop command, and busy after an R1b response to any other command. Response and busy timeouts each have two bits, split by whether the command was an automatic stop. Two summary outputs give the response and data timeout state. All counting happens only on card-clock enable ticks, so a stopped card clock freezes every wait.

Top module: `sd_timeout_monitor`

## Requirements
- R1: After `cmd_sent_i`, if no `resp_rcvd_i` arrives, the response bit sets on the 640th `clk_en_i` tick that follows. The bit is `to_bits_o[1]` if `auto_stop_i` was high with `cmd_sent_i`, otherwise `to_bits_o[0]`.
- R2: A `resp_rcvd_i` before the limit ends the response wait, so no response bit sets. A new `cmd_sent_i` restarts the wait from zero.
- R3: The data-phase limit is 2^(13+`top_i`) ticks for `top_i` values 0 to 14. With `top_i` = 15, no data timeout bit (`to_bits_o[6:2]`) sets.
- R4: After `wr_blk_sent_i`, the CRC status bit `to_bits_o[2]` sets when `crc_tok_rcvd_i` has not arrived within the limit.
- R5: After `crc_tok_rcvd_i`, the CRC busy bit `to_bits_o[3]` sets when DAT0 stays low for the limit. The wait ends on the first tick with `dat0_i` high.
- R6: The read bit `to_bits_o[4]` sets when no read block arrives within the limit. The wait starts on `cmd_sent_i` with `rd_cmd_i` high, on `rd_blk_rcvd_i` with `rd_last_i` low, and on `rd_wait_exit_i`. It ends on a last block, on `cmd_sent_i` with `rd_cmd_i` low, and while `rd_wait_i` is high.
- R7: After `r1b_rcvd_i`, a busy wait runs until a tick with `dat0_i` high. If the wait exceeds the limit, `to_bits_o[6]` sets for an automatic stop command and `to_bits_o[5]` sets otherwise.
- R8: `resp_to_o` is the OR of `to_bits_o[1:0]`. `data_to_o` is the OR of `to_bits_o[6:2]`.
- R9: The timeout bits are sticky. `cmd_wr_i` or `srst_i` clears them on the next edge, and a clear wins over a timeout in the same cycle. `srst_i` also cancels every wait in progress.
- R10: Counts advance only on cycles where `clk_en_i` is high. No bit sets on a cycle where `clk_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_en_i | input | 1 | Card-clock tick |
| srst_i | input | 1 | Soft reset of the host |
| cmd_wr_i | input | 1 | Write to the command register |
| top_i | input | 4 | Data timeout period selection |
| cmd_sent_i | input | 1 | Command issued strobe |
| auto_stop_i | input | 1 | Command is an automatic stop command (valid with cmd_sent_i) |
| rd_cmd_i | input | 1 | Command starts a read (valid with cmd_sent_i) |
| resp_rcvd_i | input | 1 | Response received strobe |
| wr_blk_sent_i | input | 1 | Write block sent strobe |
| crc_tok_rcvd_i | input | 1 | CRC status token received strobe |
| rd_blk_rcvd_i | input | 1 | Read block received strobe |
| rd_last_i | input | 1 | Read block is the last one (valid with rd_blk_rcvd_i) |
| rd_wait_i | input | 1 | Read-wait state active |
| rd_wait_exit_i | input | 1 | Read-wait exit strobe |
| r1b_rcvd_i | input | 1 | R1b response received strobe |
| dat0_i | input | 1 | Sampled DAT0 level, low means busy |
| to_bits_o | output | 7 | Sticky timeout bits |
| resp_to_o | output | 1 | Response timeout summary |
| data_to_o | output | 1 | Data timeout summary |

## Verification
On every cycle the assertions check that bits are sticky, that a clear empties them, that no bit appears on a cycle without a tick, and that no data bit appears while the period field is 15. Exact expiry timing cannot be shown by a cycle-local property. The same holds for the choice of bit by the stop qualifier, for a response or a DAT0 release that cancels a wait, and for read-wait suspension. The bench shows these through scenarios checked against a tick-counting model on every clock.

// File: rtl/sdtm_pkg.sv
package sdtm_pkg;
  localparam int N_WATCH = 5;
  localparam int N_BITS  = 7;

  typedef enum int {
    W_RESP   = 0,
    W_CRCTOK = 1,
    W_CRCBSY = 2,
    W_READ   = 3,
    W_BUSY   = 4
  } watch_e;

  typedef enum int {
    B_RESP_N = 0,
    B_RESP_A = 1,
    B_CRCTOK = 2,
    B_CRCBSY = 3,
    B_READ   = 4,
    B_BUSY_N = 5,
    B_BUSY_A = 6
  } bit_e;
endpackage

// File: rtl/sdtm_period.sv
module sdtm_period #(
  parameter int BASE_LOG = 13,
  parameter int TOP_W    = 4,
  parameter int CW       = 29
) (
  input  logic [TOP_W-1:0] top_i,
  output logic [CW-1:0]    limit_o,
  output logic             en_o
);
  localparam logic [TOP_W-1:0] TOP_OFF = '1;

  assign en_o    = (top_i != TOP_OFF);
  assign limit_o = CW'(1) << (BASE_LOG + int'(top_i));
endmodule

// File: rtl/sdtm_watch.sv
module sdtm_watch #(
  parameter int CW = 29
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          srst_i,
  input  logic          arm_i,
  input  logic          stop_i,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic [CW-1:0] limit_i,
  output logic          expire_o
);
  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;
  logic          step;

  assign cnt_inc  = cnt_q + CW'(1);
  assign step     = armed_q & tick_i & en_i & ~arm_i & ~stop_i & ~srst_i;
  assign expire_o = step & (cnt_inc == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (srst_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (stop_i) begin
      armed_q <= 1'b0;
    end else if (step) begin
      if (expire_o) armed_q <= 1'b0;
      else          cnt_q   <= cnt_inc;
    end
  end
endmodule

// File: rtl/sd_timeout_monitor.sv
module sd_timeout_monitor
  import sdtm_pkg::*;
#(
  parameter int BASE_LOG   = 13,
  parameter int RESP_LIMIT = 640
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clk_en_i,
  input  logic       srst_i,
  input  logic       cmd_wr_i,
  input  logic [3:0] top_i,
  input  logic       cmd_sent_i,
  input  logic       auto_stop_i,
  input  logic       rd_cmd_i,
  input  logic       resp_rcvd_i,
  input  logic       wr_blk_sent_i,
  input  logic       crc_tok_rcvd_i,
  input  logic       rd_blk_rcvd_i,
  input  logic       rd_last_i,
  input  logic       rd_wait_i,
  input  logic       rd_wait_exit_i,
  input  logic       r1b_rcvd_i,
  input  logic       dat0_i,
  output logic [6:0] to_bits_o,
  output logic       resp_to_o,
  output logic       data_to_o
);
  localparam int TOP_W = 4;
  localparam int CW    = BASE_LOG + (1 << TOP_W);

  logic [CW-1:0]      data_lim;
  logic               data_en;
  logic [N_WATCH-1:0] arm, stop, en, expire;
  logic [CW-1:0]      lim [N_WATCH];
  logic               auto_q;
  logic [N_BITS-1:0]  bits_q, bits_set;
  logic               released;

  sdtm_period #(.BASE_LOG(BASE_LOG), .TOP_W(TOP_W), .CW(CW)) u_period (
    .top_i  (top_i),
    .limit_o(data_lim),
    .en_o   (data_en)
  );

  assign released = clk_en_i & dat0_i;

  always_comb begin
    for (int i = 0; i < N_WATCH; i++) begin
      lim[i] = data_lim;
      en[i]  = data_en;
    end
    lim[W_RESP] = CW'(RESP_LIMIT);
    en[W_RESP]  = 1'b1;

    arm[W_RESP]    = cmd_sent_i;
    stop[W_RESP]   = resp_rcvd_i;
    arm[W_CRCTOK]  = wr_blk_sent_i;
    stop[W_CRCTOK] = crc_tok_rcvd_i;
    arm[W_CRCBSY]  = crc_tok_rcvd_i;
    stop[W_CRCBSY] = released;
    arm[W_READ]    = ~rd_wait_i & ((cmd_sent_i & rd_cmd_i) | (rd_blk_rcvd_i & ~rd_last_i)
                                   | rd_wait_exit_i);
    stop[W_READ]   = rd_wait_i | (rd_blk_rcvd_i & rd_last_i) | (cmd_sent_i & ~rd_cmd_i);
    arm[W_BUSY]    = r1b_rcvd_i;
    stop[W_BUSY]   = released;
  end

  for (genvar g = 0; g < N_WATCH; g++) begin : g_watch
    sdtm_watch #(.CW(CW)) u_watch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .srst_i  (srst_i),
      .arm_i   (arm[g]),
      .stop_i  (stop[g]),
      .tick_i  (clk_en_i),
      .en_i    (en[g]),
      .limit_i (lim[g]),
      .expire_o(expire[g])
    );
  end

  always_comb begin
    bits_set           = '0;
    bits_set[B_RESP_N] = expire[W_RESP] & ~auto_q;
    bits_set[B_RESP_A] = expire[W_RESP] &  auto_q;
    bits_set[B_CRCTOK] = expire[W_CRCTOK];
    bits_set[B_CRCBSY] = expire[W_CRCBSY];
    bits_set[B_READ]   = expire[W_READ];
    bits_set[B_BUSY_N] = expire[W_BUSY] & ~auto_q;
    bits_set[B_BUSY_A] = expire[W_BUSY] &  auto_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_q <= 1'b0;
      bits_q <= '0;
    end else begin
      if (srst_i)          auto_q <= 1'b0;
      else if (cmd_sent_i) auto_q <= auto_stop_i;
      if (srst_i || cmd_wr_i) bits_q <= '0;
      else                    bits_q <= bits_q | bits_set;
    end
  end

  assign to_bits_o = bits_q;
  assign resp_to_o = bits_q[B_RESP_N] | bits_q[B_RESP_A];
  assign data_to_o = |bits_q[B_BUSY_A:B_CRCTOK];
endmodule

// File: rtl/sdtm_chk.sv
module sdtm_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       clk_en_i,
  input logic       srst_i,
  input logic       cmd_wr_i,
  input logic [3:0] top_i,
  input logic [6:0] to_bits_o,
  input logic       resp_to_o,
  input logic       data_to_o
);
  // R9
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_wr_i && !srst_i) |=> ((to_bits_o & $past(to_bits_o)) == $past(to_bits_o)));

  // R9
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i || srst_i) |=> (to_bits_o == 7'd0));

  // R10
  tick_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> ((to_bits_o & ~$past(to_bits_o)) == 7'd0));

  // R3
  data_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_i == 4'hF) |=> ((to_bits_o[6:2] & ~$past(to_bits_o[6:2])) == 5'd0));

  // R8
  summary_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(resp_to_o) || $rose(data_to_o)) |-> (to_bits_o != $past(to_bits_o)));
endmodule

bind sd_timeout_monitor sdtm_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clk_en_i (clk_en_i),
  .srst_i   (srst_i),
  .cmd_wr_i (cmd_wr_i),
  .top_i    (top_i),
  .to_bits_o(to_bits_o),
  .resp_to_o(resp_to_o),
  .data_to_o(data_to_o)
);

// File: tb/test_sd_timeout_monitor.sv
`timescale 1ns/1ps
module test_sd_timeout_monitor;
  logic clk = 1'b0, rst_n = 1'b0;
  logic clk_en = 1'b1, srst = 0, cmd_wr = 0;
  logic [3:0] top = 4'd0;
  logic cmd_sent = 0, auto_stop = 0, rd_cmd = 0, resp_rcvd = 0, wr_blk = 0, crc_tok = 0;
  logic rd_blk = 0, rd_last = 0, rd_wait = 0, rd_wait_exit = 0, r1b = 0, dat0 = 1;
  logic [6:0] to_bits;
  logic resp_to, data_to;

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R9";
  bit model_on = 0;

  // reference model state
  int m_el [5];
  bit m_on [5];
  bit m_auto = 0;
  logic [6:0] m_bits = '0;

  always #5 clk = ~clk;

  sd_timeout_monitor i_sd_timeout_monitor (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(clk_en), .srst_i(srst), .cmd_wr_i(cmd_wr),
    .top_i(top), .cmd_sent_i(cmd_sent), .auto_stop_i(auto_stop), .rd_cmd_i(rd_cmd),
    .resp_rcvd_i(resp_rcvd), .wr_blk_sent_i(wr_blk), .crc_tok_rcvd_i(crc_tok),
    .rd_blk_rcvd_i(rd_blk), .rd_last_i(rd_last), .rd_wait_i(rd_wait),
    .rd_wait_exit_i(rd_wait_exit), .r1b_rcvd_i(r1b), .dat0_i(dat0),
    .to_bits_o(to_bits), .resp_to_o(resp_to), .data_to_o(data_to)
  );

  function automatic bit step_w(int w, bit arm, bit stp, int lim, bit en);
    if (srst) begin m_on[w] = 0; return 0; end
    if (arm) begin m_on[w] = 1; m_el[w] = 0; return 0; end
    if (stp) begin m_on[w] = 0; return 0; end
    if (m_on[w] && clk_en && en) begin
      m_el[w]++;
      if (m_el[w] >= lim) begin m_on[w] = 0; return 1; end
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      int dl;
      bit den, e0, e1, e2, e3, e4;
      logic [6:0] nb;
      dl  = 1 << (13 + int'(top));
      den = (top != 4'd15);
      e0 = step_w(0, cmd_sent, resp_rcvd, 640, 1'b1);
      e1 = step_w(1, wr_blk, crc_tok, dl, den);
      e2 = step_w(2, crc_tok, clk_en && dat0, dl, den);
      e3 = step_w(3, !rd_wait && ((cmd_sent && rd_cmd) || (rd_blk && !rd_last) || rd_wait_exit),
                  rd_wait || (rd_blk && rd_last) || (cmd_sent && !rd_cmd), dl, den);
      e4 = step_w(4, r1b, clk_en && dat0, dl, den);
      nb = {e4 && m_auto, e4 && !m_auto, e3, e2, e1, e0 && m_auto, e0 && !m_auto};
      if (srst || cmd_wr) m_bits = '0; else m_bits = m_bits | nb;
      if (srst) m_auto = 0; else if (cmd_sent) m_auto = auto_stop;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    cycles++;
    if (model_on) begin
      check(cur_req, 32'(to_bits), 32'(m_bits), "bits vs model");
      check("R8", 32'(resp_to), 32'(m_bits[1] | m_bits[0]), "resp summary");
      check("R8", 32'(data_to), 32'(|m_bits[6:2]), "data summary");
    end
    if (cycles > 195000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  task automatic clear_bits();
    pulse(cmd_wr); @(negedge clk);
    check("R9", 32'(to_bits), 32'd0, "cleared by command write");
  endtask

  initial begin
    idle(2);
    check("R9", 32'(to_bits), 32'd0, "reset state");
    rst_n = 1'b1;
    @(negedge clk);
    model_on = 1;

    // R1: plain command, no response
    cur_req = "R1";
    auto_stop = 0; pulse(cmd_sent);
    idle(638);
    check("R1", 32'(to_bits[0]), 32'd0, "before 640 ticks");
    idle(2);
    check("R1", 32'(to_bits), 32'h01, "response bit normal");
    check("R8", 32'(resp_to), 32'd1, "resp summary set");
    clear_bits();

    // R1: automatic stop command
    auto_stop = 1; pulse(cmd_sent); auto_stop = 0;
    idle(645);
    check("R1", 32'(to_bits), 32'h02, "response bit auto stop");
    clear_bits();

    // R2: response in time, then restart
    cur_req = "R2";
    pulse(cmd_sent); idle(300); pulse(resp_rcvd); idle(700);
    check("R2", 32'(to_bits), 32'd0, "answered command");
    pulse(cmd_sent); idle(400); pulse(cmd_sent); idle(400);
    check("R2", 32'(to_bits), 32'd0, "restart from zero");
    idle(300);
    check("R2", 32'(to_bits), 32'h01, "restarted wait expires");
    clear_bits();

    // R10: ticks every other cycle
    cur_req = "R10";
    pulse(cmd_sent);
    for (int i = 0; i < 700; i++) begin clk_en = i[0]; @(negedge clk); end
    check("R10", 32'(to_bits), 32'd0, "half rate not yet expired");
    for (int i = 0; i < 700; i++) begin clk_en = i[0]; @(negedge clk); end
    clk_en = 1;
    check("R10", 32'(to_bits), 32'h01, "half rate expired");
    clear_bits();

    // R4: CRC status token missing
    cur_req = "R4";
    pulse(wr_blk); idle(8195);
    check("R4", 32'(to_bits), 32'h04, "crc status timeout");
    check("R8", 32'(data_to), 32'd1, "data summary set");
    clear_bits();

    // R5: card busy after token
    cur_req = "R5";
    dat0 = 0; pulse(crc_tok); idle(8195);
    check("R5", 32'(to_bits), 32'h08, "crc busy timeout");
    clear_bits();
    pulse(crc_tok); idle(100); dat0 = 1; idle(8200);
    check("R5", 32'(to_bits), 32'd0, "busy released in time");

    // R6: read data waits
    cur_req = "R6";
    rd_cmd = 1; pulse(cmd_sent); rd_cmd = 0; idle(5); pulse(resp_rcvd);
    idle(5000); pulse(rd_blk); idle(5000);
    check("R6", 32'(to_bits), 32'd0, "next block restarts wait");
    idle(3300);
    check("R6", 32'(to_bits), 32'h10, "read data timeout");
    clear_bits();
    rd_cmd = 1; pulse(cmd_sent); rd_cmd = 0; pulse(resp_rcvd);
    idle(3000); rd_wait = 1; idle(9000); rd_wait = 0; pulse(rd_wait_exit);
    check("R6", 32'(to_bits), 32'd0, "read wait suspends");
    idle(8200);
    check("R6", 32'(to_bits), 32'h10, "timeout after read wait exit");
    clear_bits();

    // R7: busy after R1b, split by qualifier
    cur_req = "R7";
    auto_stop = 1; pulse(cmd_sent); auto_stop = 0; pulse(resp_rcvd);
    dat0 = 0; pulse(r1b); idle(8195);
    check("R7", 32'(to_bits), 32'h40, "busy after auto stop");
    clear_bits();
    pulse(cmd_sent); pulse(resp_rcvd); pulse(r1b); idle(8195); dat0 = 1;
    check("R7", 32'(to_bits), 32'h20, "busy after other R1b");
    clear_bits();

    // R3: period field
    cur_req = "R3";
    top = 4'd15; pulse(wr_blk); idle(9000);
    check("R3", 32'(to_bits), 32'd0, "field 15 disables");
    top = 4'd1; pulse(wr_blk); idle(9000);
    check("R3", 32'(to_bits), 32'd0, "field 1 longer period");
    idle(7400);
    check("R3", 32'(to_bits), 32'h04, "field 1 expiry");
    top = 4'd0;

    // R9: soft reset clears and cancels
    cur_req = "R9";
    pulse(srst); @(negedge clk);
    check("R9", 32'(to_bits), 32'd0, "soft reset clears");
    pulse(wr_blk); idle(4000); pulse(srst); idle(5000);
    check("R9", 32'(to_bits), 32'd0, "soft reset cancels wait");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule